// File: doc/BRIEF.md
# DMA Interrupt Mask and Latch

This block sits between the DMA engine's fault and event detectors and the host interrupt pin. Each DMA condition arrives as a one-cycle pulse on its own bit of an event vector. The block records every condition in a status register and raises a summary pending flag. It also sends a one-cycle halt request to the script sequencer, because every DMA condition is fatal.

A read/write enable mask decides which conditions may drive the active-low interrupt line. Masking one condition never hides the others. Once the line is driven low it stays latched until software reads the status register. That read returns the pending bits and clears them in the same access.

The register bus is deliberately simple:

- A select bit chooses the mask register (0) or the status register (1).
- Writes take effect on the clock edge.
- Read data is combinational while the read strobe is high.

Top module: `dma_irq_gate`

## Requirements
- R1: Event, mask and status share one bit layout: bit 0 illegal instruction, bit 2 script interrupt instruction, bit 3 single step, bit 4 abort, bit 5 bus fault, bit 6 master data parity error. Select 0 addresses the mask (read/write) and select 1 addresses the status (read-only; writes to it are ignored).
- R2: After reset the mask and status read 0x00, irq_n_o is 1, and pend_o and halt_o are 0.
- R3: An event whose mask bit is 1 drives irq_n_o low on the clock edge that samples the event.
- R4: An event whose mask bit is 0 still sets its status bit and pend_o on that edge, and leaves irq_n_o high.
- R5: Any defined event raises halt_o for exactly the one cycle after the edge that samples it, whatever the mask.
- R6: Once low, irq_n_o stays low until a status read, even if the mask is cleared meanwhile.
- R7: A masked event arriving together with an unmasked event does not prevent irq_n_o from going low.
- R8: A status read returns the pending bits and clears them. If no event arrives in that cycle, pend_o goes to 0 and irq_n_o goes to 1 on the next edge.
- R9: An event that arrives in the same cycle as a clearing status read is kept. Its status bit stays set, and irq_n_o is low after the edge if that event is unmasked.
- R10: Bits 1 and 7 are reserved. They read as 0, ignore writes, and events on them set nothing and raise no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle DMA event pulses, one per bit |
| reg_sel_i | input | 1 | 0 selects the mask register, 1 selects the status register |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; a status read clears the status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, 0 when not reading |
| irq_n_o | output | 1 | Latched active-low interrupt |
| pend_o | output | 1 | Any DMA status bit pending |
| halt_o | output | 1 | One-cycle halt request to the sequencer |

## Verification
The bench drives events into the same cycle as a clearing read. A design that let the clear win would lose that condition, leaving pend_o low and the interrupt released.

It clears the mask while the interrupt is latched. A design that recomputed the line from the mask would release it too early.

It fires masked and unmasked events together. A design that gated the whole output on any masked bit would keep the line high.

It pulses the reserved bit positions and writes ones to them. A design that decoded them would show stray status bits or a spurious halt.

// File: rtl/dma_irq_gate.sv
module dma_irq_gate #(
  parameter int          W       = 8,
  parameter logic [W-1:0] DEF_BITS = 8'h7D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         reg_sel_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_n_o,
  output logic         pend_o,
  output logic         halt_o
);

  logic [W-1:0] mask_q, stat_q;
  logic         irq_q, halt_q;

  wire         wr_mask = reg_wr_i & ~reg_sel_i;
  wire         rd_stat = reg_rd_i & reg_sel_i;
  wire [W-1:0] evt     = evt_i & DEF_BITS;
  wire         evt_any = |evt;
  wire         evt_en  = |(evt & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i & DEF_BITS;
      stat_q <= (rd_stat ? '0 : stat_q) | evt;
      irq_q  <= (irq_q & ~rd_stat) | evt_en;
      halt_q <= evt_any;
    end
  end

  assign reg_rdata_o = !reg_rd_i ? '0 : (reg_sel_i ? stat_q : mask_q);
  assign pend_o      = |stat_q;
  assign irq_n_o     = ~irq_q;
  assign halt_o      = halt_q;

endmodule

module dma_irq_gate_chk #(
  parameter int          W       = 8,
  parameter logic [W-1:0] DEF_BITS = 8'h7D
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic         reg_sel_i,
  input logic         reg_rd_i,
  input logic [W-1:0] reg_rdata_o,
  input logic         irq_n_o,
  input logic         pend_o,
  input logic         halt_o,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] stat_q
);

  // R3
  unmasked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & mask_q & DEF_BITS) |=> !irq_n_o);

  // R4
  masked_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & DEF_BITS) |=> (pend_o && ((stat_q & $past(evt_i & DEF_BITS)) == $past(evt_i & DEF_BITS))));

  // R5
  halt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & DEF_BITS) |=> halt_o);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(evt_i & DEF_BITS)) |=> !halt_o);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !(reg_rd_i && reg_sel_i)) |=> !irq_n_o);

  // R8
  clear_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_sel_i && !(|(evt_i & DEF_BITS))) |=> (!pend_o && irq_n_o));

  // R10
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~DEF_BITS) == '0);

endmodule

bind dma_irq_gate dma_irq_gate_chk #(.W(W), .DEF_BITS(DEF_BITS)) u_chk (.*);

// File: tb/dma_irq_gate_tb.sv
module dma_irq_gate_tb;
  localparam logic [7:0] DEF = 8'h7D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0, reg_wdata_i = '0;
  logic       reg_sel_i = 1'b0, reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic       irq_n_o, pend_o, halt_o;

  always #2 clk = ~clk;

  dma_irq_gate u_dut (.*);

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       irq_n, pend, halt;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_mask = '0, m_st = '0;
  logic       m_irq = 0, m_halt = 0;

  function automatic void cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endfunction

  task automatic step(logic [7:0] evt, logic sel, logic wr, logic rd, logic [7:0] wd, string tag);
    item_t it;
    logic [7:0] ev;
    @(negedge clk);
    evt_i = evt; reg_sel_i = sel; reg_wr_i = wr; reg_rd_i = rd; reg_wdata_i = wd;
    ev = evt & DEF;
    it.tag = tag;
    it.rd  = rd ? (sel ? m_st : m_mask) : 8'h00;
    m_irq  = (m_irq && !(rd && sel)) || (|(ev & m_mask));
    m_st   = ((rd && sel) ? 8'h00 : m_st) | ev;
    m_halt = |ev;
    if (wr && !sel) m_mask = wd & DEF;
    it.irq_n = !m_irq; it.pend = |m_st; it.halt = m_halt;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, tag);
  endtask

  initial begin : monitor
    item_t prev;
    bit have = 0;
    forever begin
      @(negedge clk); #1;
      if (have) begin
        cmp(prev.tag, "irq_n", {7'b0, irq_n_o}, {7'b0, prev.irq_n});
        cmp(prev.tag, "pend",  {7'b0, pend_o},  {7'b0, prev.pend});
        cmp(prev.tag, "halt",  {7'b0, halt_o},  {7'b0, prev.halt});
      end
      have = 0;
      if (q.size() > 0) begin
        prev = q.pop_front();
        cmp(prev.tag, "rdata", reg_rdata_o, prev.rd);
        have = 1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 idle outputs straight out of reset
    cmp("R2 reset", "irq_n", {7'b0, irq_n_o}, 8'h01);
    cmp("R2 reset", "pend",  {7'b0, pend_o},  8'h00);
    cmp("R2 reset", "halt",  {7'b0, halt_o},  8'h00);
    rst_n = 1'b1;
    step(8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R2 mask after reset");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R2 status after reset");
    // R10 reserved mask bits ignore writes; R1 layout
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'hFF, "R10 mask write all ones");
    step(8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R1 mask readback");
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R1 mask clear");
    // R4 / R5 masked bus fault
    step(8'h20, 1'b0, 1'b0, 1'b0, 8'h00, "R4 masked bus fault");
    idle("R5 halt one cycle");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R8 status read clears");
    idle("R8 after clear");
    // R3 unmasked illegal instruction
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h01, "R1 mask bit0");
    step(8'h01, 1'b0, 1'b0, 1'b0, 8'h00, "R3 unmasked event");
    // R6 latched through mask clear
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R6 mask cleared");
    idle("R6 hold");
    idle("R6 hold");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R8 read releases irq");
    idle("R8 released");
    // R7 masked abort with unmasked parity error
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h40, "R1 mask bit6");
    step(8'h50, 1'b0, 1'b0, 1'b0, 8'h00, "R7 mixed events");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R7 status of mixed");
    // R9 masked event during clearing read
    step(8'h04, 1'b0, 1'b0, 1'b0, 8'h00, "R4 masked script int");
    step(8'h08, 1'b1, 1'b0, 1'b1, 8'h00, "R9 masked event at clear");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R9 kept bit read");
    // R9 unmasked event during clearing read
    step(8'h40, 1'b0, 1'b0, 1'b0, 8'h00, "R3 parity error");
    step(8'h40, 1'b1, 1'b0, 1'b1, 8'h00, "R9 unmasked at clear");
    idle("R9 irq stays");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R9 kept parity read");
    // R10 reserved events
    step(8'h82, 1'b0, 1'b0, 1'b0, 8'h00, "R10 reserved events");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R10 no reserved status");
    // R1 status is read-only
    step(8'h10, 1'b0, 1'b0, 1'b0, 8'h00, "R4 masked abort");
    step(8'h00, 1'b1, 1'b1, 1'b0, 8'h00, "R1 status write ignored");
    step(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R1 status after write");
    idle("R8 final");
    idle("flush");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule